// File: doc/BRIEF.md
# Forwarding Store Buffer

This block sits between a core's store pipeline and its data cache. A store to a line that the core does not yet hold exclusively is parked in a small in-order queue. The queue then asks the coherence side for ownership of the line at its oldest entry. The oldest entry is written to the cache in the cycle ownership for it is granted, or in a later cycle if the cache write port is busy then. A store that arrives with its line already held exclusively, and that has no parked entry at the same doubleword, goes to the cache at once. This lets stores become visible out of program order. A fence input holds back later instructions until the queue has drained.

Every entry carries a thread tag. A load presents its thread, doubleword address and the bytes it needs. The buffer searches only that thread's entries and picks the youngest one at the same doubleword. If that entry covers every needed byte, its data is forwarded. If it covers only some of them, the load must stall until the entry reaches the cache. If no entry matches, the load is served from the cache.

Top module: `store_buffer_fwd`

## Requirements
- R1: A store with `st_owned`=0 that is accepted is parked. While the oldest parked entry waits, `own_req` is 1 and `own_addr` is that entry's doubleword address. Nothing from the queue is written to the cache before a grant.
- R2: Parked entries are written to the cache strictly oldest first, at most one per cycle. When `own_gnt` is 1 in a cycle where `own_req` is 1, the oldest entry appears on the cache write port in that same cycle. If the port is taken that cycle, the grant is remembered and the entry is written in the next free cycle without a new grant.
- R3: A store with `st_owned`=1, when no parked entry of any thread has its doubleword address, is written to the cache in the same cycle and is not parked. It takes the write port ahead of a queue commit.
- R4: A store with `st_owned`=1 whose doubleword address matches a parked entry is parked like an unowned store, so it cannot overtake the older data.
- R5: A load hits when the youngest parked entry with the same thread and doubleword address has every byte of `ld_mask` set in its byte mask. In that case `ld_hit`=1, `ld_stall`=0, and `ld_data` holds the entry's bytes, with bytes not requested forced to zero. Byte i is bits 8i+7..8i.
- R6: If that youngest matching entry lacks any requested byte, then `ld_stall`=1 and `ld_hit`=0, even if an older entry would cover the bytes. Once the entry has been written to the cache, the same load no longer matches.
- R7: Entries of other threads are never used by a load. With no matching entry, `ld_hit`=0, `ld_stall`=0 and `ld_data`=0.
- R8: With all DEPTH entries occupied, a store that cannot bypass is refused: `st_stall`=1 and nothing is recorded.
- R9: `fence_stall` is 1 exactly while `fence_req` is 1 and the queue is not empty. While it is 1, every presented store is refused with `st_stall`=1.
- R10: After reset the queue is empty, and `own_req`, `cw_valid` and `fence_stall` are 0. Load lookups see only entries parked in earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented |
| st_owned | input | 1 | Store's line is already held exclusively |
| st_tid | input | 2 | Store thread tag |
| st_addr | input | 29 | Store doubleword address |
| st_data | input | 64 | Store data |
| st_mask | input | 8 | Store byte mask |
| st_stall | output | 1 | Presented store refused this cycle |
| ld_valid | input | 1 | Load lookup presented |
| ld_tid | input | 2 | Load thread tag |
| ld_addr | input | 29 | Load doubleword address |
| ld_mask | input | 8 | Bytes the load needs |
| ld_hit | output | 1 | Full forward from the queue |
| ld_stall | output | 1 | Partial overlap, load must wait |
| ld_data | output | 64 | Forwarded data |
| own_req | output | 1 | Ownership request for the oldest entry |
| own_addr | output | 29 | Doubleword address being requested |
| own_gnt | input | 1 | Ownership granted |
| cw_valid | output | 1 | Cache write this cycle |
| cw_addr | output | 29 | Cache write doubleword address |
| cw_data | output | 64 | Cache write data |
| cw_mask | output | 8 | Cache write byte mask |
| fence_req | input | 1 | Store fence pending at issue |
| fence_stall | output | 1 | Later instructions must wait |

## Verification
Two things can need the single cache write port in the same cycle: an owned store bypassing the queue, and a queue commit whose grant has just arrived. The bench creates this case by parking one entry and then, in one cycle, raising `own_gnt` while presenting an owned store to another doubleword. It judges the result by the port: the bypass address must appear in that cycle, and the parked entry must follow in the next cycle with `own_gnt` already low. That proves the grant was held over rather than lost.

// File: rtl/sb_pkg.sv
package sb_pkg;
    parameter int SB_AW = 29;
    parameter int SB_TW = 2;
    parameter int SB_NB = 8;
    localparam int SB_DW = SB_NB * 8;

    typedef struct packed {
        logic             vld;
        logic [SB_TW-1:0] tid;
        logic [SB_AW-1:0] addr;
        logic [SB_DW-1:0] data;
        logic [SB_NB-1:0] mask;
    } sb_entry_t;

    function automatic logic [SB_DW-1:0] byte_expand(input logic [SB_NB-1:0] m);
        logic [SB_DW-1:0] r;
        for (int i = 0; i < SB_NB; i++) begin
            r[i*8 +: 8] = {8{m[i]}};
        end
        return r;
    endfunction
endpackage

// File: rtl/sb_lookup.sv
module sb_lookup
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  sb_entry_t [DEPTH-1:0] ents,
    input  logic [IW-1:0]         head,
    input  logic                  use_tid,
    input  logic [SB_TW-1:0]      tid,
    input  logic [SB_AW-1:0]      addr,
    output logic                  found,
    output logic [IW-1:0]         idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int j;
            j = int'(head) + k;
            if (j >= DEPTH) j = j - DEPTH;
            if (ents[j].vld && ents[j].addr == addr &&
                (!use_tid || ents[j].tid == tid)) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/sb_commit_ctrl.sv
module sb_commit_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic head_vld,
    input  logic own_gnt,
    input  logic port_busy,
    output logic own_req,
    output logic commit
);
    logic granted_d, granted_q;

    always_comb begin
        own_req   = head_vld && !granted_q;
        commit    = head_vld && (granted_q || own_gnt) && !port_busy;
        granted_d = commit ? 1'b0 : (granted_q || (head_vld && own_gnt));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) granted_q <= 1'b0;
        else        granted_q <= granted_d;
    end
endmodule

// File: rtl/store_buffer_fwd.sv
module store_buffer_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             st_owned,
    input  logic [SB_TW-1:0] st_tid,
    input  logic [SB_AW-1:0] st_addr,
    input  logic [SB_DW-1:0] st_data,
    input  logic [SB_NB-1:0] st_mask,
    output logic             st_stall,
    input  logic             ld_valid,
    input  logic [SB_TW-1:0] ld_tid,
    input  logic [SB_AW-1:0] ld_addr,
    input  logic [SB_NB-1:0] ld_mask,
    output logic             ld_hit,
    output logic             ld_stall,
    output logic [SB_DW-1:0] ld_data,
    output logic             own_req,
    output logic [SB_AW-1:0] own_addr,
    input  logic             own_gnt,
    output logic             cw_valid,
    output logic [SB_AW-1:0] cw_addr,
    output logic [SB_DW-1:0] cw_data,
    output logic [SB_NB-1:0] cw_mask,
    input  logic             fence_req,
    output logic             fence_stall
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        sb_entry_t [DEPTH-1:0] ent;
        logic [IW-1:0]         head;
        logic [IW-1:0]         tail;
        logic [CW-1:0]         count;
    } state_t;

    state_t q, d;

    logic          ld_found, st_found, commit, bypass, accept, full;
    logic [IW-1:0] ld_idx, st_idx;
    sb_entry_t     head_e, ld_e;

    function automatic logic [IW-1:0] ptr_inc(input logic [IW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    sb_lookup #(.DEPTH(DEPTH), .IW(IW)) u_ld_look (
        .ents(q.ent), .head(q.head), .use_tid(1'b1), .tid(ld_tid),
        .addr(ld_addr), .found(ld_found), .idx(ld_idx)
    );

    sb_lookup #(.DEPTH(DEPTH), .IW(IW)) u_st_look (
        .ents(q.ent), .head(q.head), .use_tid(1'b0), .tid(st_tid),
        .addr(st_addr), .found(st_found), .idx(st_idx)
    );

    sb_commit_ctrl u_commit (
        .clk(clk), .rst_n(rst_n), .head_vld(head_e.vld), .own_gnt(own_gnt),
        .port_busy(bypass), .own_req(own_req), .commit(commit)
    );

    always_comb begin
        head_e      = q.ent[q.head];
        ld_e        = q.ent[ld_idx];
        full        = (int'(q.count) == DEPTH);
        fence_stall = fence_req && (q.count != '0);
        bypass      = st_valid && st_owned && !st_found && !fence_stall;
        accept      = st_valid && !bypass && !full && !fence_stall;
        st_stall    = st_valid && !bypass && !accept;
        own_addr    = head_e.addr;

        cw_valid = bypass || commit;
        cw_addr  = bypass ? st_addr : head_e.addr;
        cw_data  = bypass ? st_data : head_e.data;
        cw_mask  = bypass ? st_mask : head_e.mask;

        ld_hit   = 1'b0;
        ld_stall = 1'b0;
        ld_data  = '0;
        if (ld_valid && ld_found) begin
            if ((ld_e.mask & ld_mask) == ld_mask) begin
                ld_hit  = 1'b1;
                ld_data = ld_e.data & byte_expand(ld_mask);
            end else begin
                ld_stall = 1'b1;
            end
        end

        d = q;
        if (commit) begin
            d.ent[q.head].vld = 1'b0;
            d.head            = ptr_inc(q.head);
        end
        if (accept) begin
            d.ent[q.tail] = '{vld: 1'b1, tid: st_tid, addr: st_addr,
                              data: st_data, mask: st_mask};
            d.tail        = ptr_inc(q.tail);
        end
        d.count = q.count + CW'(accept) - CW'(commit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_stall,
    input logic          bypass,
    input logic          own_req,
    input logic          own_gnt,
    input logic          cw_valid,
    input logic          ld_hit,
    input logic          ld_stall,
    input logic          fence_stall,
    input logic [CW-1:0] count_q
);
    assert_grant_writes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (own_req && own_gnt && !bypass) |-> cw_valid);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count_q) <= DEPTH);

    assert_full_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count_q) == DEPTH && st_valid && !bypass) |-> st_stall);

    assert_hit_stall_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_hit && ld_stall));

    assert_fence_no_growth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fence_stall |=> count_q <= $past(count_q));

    assert_idle_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == '0) |-> !own_req);
endmodule

bind store_buffer_fwd sb_checker #(.DEPTH(DEPTH), .CW(CW)) u_sb_checker (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_stall(st_stall),
    .bypass(bypass), .own_req(own_req), .own_gnt(own_gnt), .cw_valid(cw_valid),
    .ld_hit(ld_hit), .ld_stall(ld_stall), .fence_stall(fence_stall),
    .count_q(q.count)
);

// File: tb/store_buffer_fwd_test.sv
module store_buffer_fwd_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 0, st_owned = 0;
    logic [1:0]  st_tid = 0;
    logic [28:0] st_addr = 0;
    logic [63:0] st_data = 0;
    logic [7:0]  st_mask = 0;
    logic        ld_valid = 0;
    logic [1:0]  ld_tid = 0;
    logic [28:0] ld_addr = 0;
    logic [7:0]  ld_mask = 0;
    logic        own_gnt = 0, fence_req = 0;
    logic        st_stall, ld_hit, ld_stall, own_req, cw_valid, fence_stall;
    logic [63:0] ld_data, cw_data;
    logic [28:0] own_addr, cw_addr;
    logic [7:0]  cw_mask;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    store_buffer_fwd uut (.*);

    typedef struct packed {
        logic [1:0]  tid;
        logic [28:0] addr;
        logic [7:0]  mask;
        logic        hit;
        logic        stall;
        logic [63:0] data;
    } ldv_t;

    localparam ldv_t LDV [9] = '{
        '{2'd0, 29'h10, 8'h0F, 1'b1, 1'b0, 64'h0000_0000_2222_2222},
        '{2'd0, 29'h10, 8'hFF, 1'b0, 1'b1, 64'h0},
        '{2'd0, 29'h10, 8'hF0, 1'b0, 1'b1, 64'h0},
        '{2'd0, 29'h20, 8'hFF, 1'b1, 1'b0, 64'h3333_3333_3333_3333},
        '{2'd1, 29'h20, 8'hFF, 1'b0, 1'b0, 64'h0},
        '{2'd1, 29'h30, 8'h03, 1'b1, 1'b0, 64'h0000_0000_0000_4444},
        '{2'd1, 29'h30, 8'hF0, 1'b0, 1'b1, 64'h0},
        '{2'd1, 29'h10, 8'hFF, 1'b1, 1'b0, 64'h5555_5555_5555_5555},
        '{2'd0, 29'h40, 8'hFF, 1'b0, 1'b0, 64'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put_store(input logic own, input logic [1:0] t, input logic [28:0] a,
                             input logic [63:0] dt, input logic [7:0] m);
        @(negedge clk);
        st_valid = 1; st_owned = own; st_tid = t; st_addr = a; st_data = dt; st_mask = m;
        #1;
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [28:0] drain_a [8];
        drain_a = '{29'h10, 29'h10, 29'h20, 29'h30, 29'h10, 29'h50, 29'h60, 29'h70};
        repeat (3) @(negedge clk);
        rst_n = 1; fence_req = 1;
        #1;
        chk("R10 own_req", own_req, 0);
        chk("R10 cw_valid", cw_valid, 0);
        chk("R10 fence_stall empty", fence_stall, 0);
        @(negedge clk); fence_req = 0;

        // R1 park five stores, no grant
        put_store(0, 0, 29'h10, 64'h1111_1111_1111_1111, 8'hFF); chk("R1 accept", st_stall, 0);
        put_store(0, 0, 29'h10, 64'h2222_2222_2222_2222, 8'h0F); chk("R1 accept", st_stall, 0);
        put_store(0, 0, 29'h20, 64'h3333_3333_3333_3333, 8'hFF); chk("R1 accept", st_stall, 0);
        put_store(0, 1, 29'h30, 64'h4444_4444_4444_4444, 8'h0F); chk("R1 accept", st_stall, 0);
        put_store(0, 1, 29'h10, 64'h5555_5555_5555_5555, 8'hFF); chk("R1 accept", st_stall, 0);
        @(negedge clk); st_valid = 0; #1;
        chk("R1 own_req", own_req, 1);
        chk("R1 own_addr", own_addr, 29'h10);
        chk("R1 no write before grant", cw_valid, 0);

        // R5 R6 R7 lookup table
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            ld_valid = 1; ld_tid = LDV[i].tid; ld_addr = LDV[i].addr; ld_mask = LDV[i].mask;
            #1;
            chk("R5 ld_hit", ld_hit, LDV[i].hit);
            chk("R6 ld_stall", ld_stall, LDV[i].stall);
            chk("R7 ld_data", ld_data, LDV[i].data);
        end
        @(negedge clk); ld_valid = 0;

        // R8 fill and overflow
        put_store(0, 2, 29'h50, 64'h50, 8'hFF);
        put_store(0, 2, 29'h60, 64'h60, 8'hFF);
        put_store(0, 2, 29'h70, 64'h70, 8'hFF); chk("R8 last slot", st_stall, 0);
        put_store(0, 2, 29'h99, 64'h99, 8'hFF); chk("R8 full refuse", st_stall, 1);

        // R9 fence
        @(negedge clk); st_valid = 0; fence_req = 1; #1;
        chk("R9 fence_stall", fence_stall, 1);
        put_store(1, 3, 29'hC0, 64'hC0, 8'hFF);
        chk("R9 store refused", st_stall, 1);
        chk("R9 no bypass", cw_valid, 0);

        // R2 drain in order
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); st_valid = 0; own_gnt = 1; #1;
            chk("R2 cw_valid", cw_valid, 1);
            chk("R2 cw_addr order", cw_addr, drain_a[k]);
        end
        @(negedge clk); own_gnt = 0; #1;
        chk("R8 refused not stored", cw_valid, 0);
        chk("R9 fence released", fence_stall, 0);
        fence_req = 0;

        // R6 after commit the load misses
        ld_valid = 1; ld_tid = 0; ld_addr = 29'h10; ld_mask = 8'hFF; #1;
        chk("R6 after commit stall", ld_stall, 0);
        chk("R6 after commit hit", ld_hit, 0);
        @(negedge clk); ld_valid = 0;

        // R3 bypass
        put_store(1, 0, 29'h80, 64'hABCD, 8'h03);
        chk("R3 bypass valid", cw_valid, 1);
        chk("R3 bypass addr", cw_addr, 29'h80);
        chk("R3 bypass data", cw_data, 64'hABCD);
        @(negedge clk); st_valid = 0; #1;
        chk("R3 not parked", own_req, 0);

        // R3 R2 port conflict
        put_store(0, 0, 29'h90, 64'h90, 8'hFF);
        @(negedge clk);
        st_valid = 1; st_owned = 1; st_addr = 29'hA0; st_data = 64'hA0; own_gnt = 1; #1;
        chk("R3 bypass wins addr", cw_addr, 29'hA0);
        @(negedge clk); st_valid = 0; own_gnt = 0; #1;
        chk("R2 held grant valid", cw_valid, 1);
        chk("R2 held grant addr", cw_addr, 29'h90);
        chk("R2 held grant req", own_req, 0);
        @(negedge clk); #1;
        chk("R2 drained", cw_valid, 0);

        // R4 owned store matching a parked entry
        put_store(0, 1, 29'hB0, 64'h0B0B, 8'hFF);
        put_store(1, 1, 29'hB0, 64'h0C0C, 8'hFF);
        chk("R4 no bypass", cw_valid, 0);
        chk("R4 accepted", st_stall, 0);
        @(negedge clk); st_valid = 0;
        ld_valid = 1; ld_tid = 1; ld_addr = 29'hB0; ld_mask = 8'hFF; #1;
        chk("R4 parked data", ld_data, 64'h0C0C);
        @(negedge clk); ld_valid = 0; own_gnt = 1; #1;
        chk("R4 old first", cw_data, 64'h0B0B);
        @(negedge clk); #1;
        chk("R4 new second", cw_data, 64'h0C0C);
        @(negedge clk); own_gnt = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule